// File: doc/BRIEF.md
# Dual-Clock Reversible Binary Counter

This block is a 4-bit binary counter that counts in both directions. It has two count strobes: one for up and one for down. A rising edge on the up strobe adds one to the count. A rising edge on the down strobe subtracts one. For each edge to count, the other strobe must be resting high at that moment. An active-high clear and an active-low load from a 4-bit data bus both take priority over counting.

Two active-low terminal outputs are provided:
- The carry output copies the low phase of the up strobe while the count is at its maximum.
- The borrow output copies the low phase of the down strobe while the count is zero.

Because of this, the carry and borrow of one stage can drive the up and down strobes of the next stage directly. Stages chained this way form wider ripple counters with no extra logic.

All strobes, load, clear and data are sampled as ordinary signals on a free-running system clock. Edges are found by comparing each sample with the one before it. Any control change takes effect on the second system-clock edge after it is applied.

Top module: `dual_clock_counter`

## Requirements
- R1: With load and clear inactive, a rising edge of `up_clk` while `dn_clk` is high raises `count` by one. The count wraps from the maximum value (all ones) to 0.
- R2: With load and clear inactive, a rising edge of `dn_clk` while `up_clk` is high lowers `count` by one. The count wraps from 0 to all ones.
- R3: A rising edge of one strobe is ignored while the other strobe is low. Rising edges on both strobes in the same sample are also ignored. In both cases `count` does not change.
- R4: `carry_n` is low only while `count` is all ones and the sampled `up_clk` is low. It returns high when `up_clk` rises.
- R5: `borrow_n` is low only while `count` is 0 and the sampled `dn_clk` is low. It returns high when `dn_clk` rises.
- R6: While `load_n` is low and `clear` is low, `count` takes the value on `data`, whatever the state of either strobe.
- R7: While `clear` is high, `count` is 0. Clear overrides load and both strobes.
- R8: A strobe held low through a load or clear, and still low after release, counts on its next rising edge.
- R9: Connecting a lower stage's `carry_n` to a higher stage's `up_clk`, and its `borrow_n` to the higher stage's `dn_clk`, makes a wider counter. That counter counts and wraps as one binary value.
- R10: After synchronous reset, `count` is 0 and both `carry_n` and `borrow_n` are high. A control change applied between clock edges shows on `count` after the second following rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| up_clk | input | 1 | Count-up strobe; counts on its rising edge |
| dn_clk | input | 1 | Count-down strobe; counts on its rising edge |
| load_n | input | 1 | Active-low parallel load |
| clear | input | 1 | Active-high clear to zero |
| data | input | WIDTH | Parallel load value |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low carry; copies low phase of `up_clk` at the maximum count |
| borrow_n | output | 1 | Active-low borrow; copies low phase of `dn_clk` at zero |

## Verification
The assertions assume every strobe, load and clear level is stable for at least one system-clock sample. This lets each edge be seen as one low sample followed by one high sample. The stimulus holds every level for three or more system clocks, so chained stages settle before the next change.

Direction reversal is only defined while the active strobe is high. The bench therefore changes a strobe only while the other one is high, except in the scenarios that deliberately test blocked and simultaneous edges.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    // Sampled control levels, one bit per control input
    typedef struct packed {
        logic up_lvl;
        logic dn_lvl;
        logic load_n;
        logic clear;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{up_lvl: 1'b1, dn_lvl: 1'b1, load_n: 1'b1, clear: 1'b0};

    // Rising edges seen between two consecutive samples
    typedef struct packed {
        logic up_rise;
        logic dn_rise;
    } edge_t;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_UP,
        ACT_DOWN,
        ACT_LOAD,
        ACT_CLEAR
    } act_e;

    // Priority: clear, then load, then a single qualified strobe edge
    function automatic act_e pick_action(ctl_t c, edge_t e);
        if (c.clear)                  return ACT_CLEAR;
        if (!c.load_n)                return ACT_LOAD;
        if (e.up_rise && e.dn_rise)   return ACT_HOLD;
        if (e.up_rise && c.dn_lvl)    return ACT_UP;
        if (e.dn_rise && c.up_lvl)    return ACT_DOWN;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/dcc_sampler.sv
module dcc_sampler
    import dcc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_clk,
    input  logic             dn_clk,
    input  logic             load_n,
    input  logic             clear,
    input  logic [WIDTH-1:0] data,
    output ctl_t             ctl_q,
    output edge_t            edg,
    output logic [WIDTH-1:0] data_q
);

    logic up_prev;
    logic dn_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= CTL_IDLE;
            up_prev <= 1'b1;
            dn_prev <= 1'b1;
            data_q  <= '0;
        end else begin
            ctl_q   <= '{up_lvl: up_clk, dn_lvl: dn_clk, load_n: load_n, clear: clear};
            up_prev <= ctl_q.up_lvl;
            dn_prev <= ctl_q.dn_lvl;
            data_q  <= data;
        end
    end

    assign edg.up_rise = ctl_q.up_lvl & ~up_prev;
    assign edg.dn_rise = ctl_q.dn_lvl & ~dn_prev;

    // R3: a rise is reported only after a low sample
    a_r3_rise_after_low: assert property (@(posedge clk) disable iff (rst)
        edg.up_rise |-> !$past(ctl_q.up_lvl));

endmodule

// File: rtl/dcc_count.sv
module dcc_count
    import dcc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl_q,
    input  edge_t            edg,
    input  logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    act_e             act;
    logic [WIDTH-1:0] count_nx;

    always_comb begin
        act = pick_action(ctl_q, edg);
        unique case (act)
            ACT_CLEAR: count_nx = '0;
            ACT_LOAD:  count_nx = data_q;
            ACT_UP:    count_nx = count + ONE;
            ACT_DOWN:  count_nx = count - ONE;
            default:   count_nx = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count_nx;
    end

    logic ctl_free;
    assign ctl_free = ctl_q.load_n && !ctl_q.clear;

    // R7
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
        ctl_q.clear |=> count == '0);
    // R6
    a_r6_load_value: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.clear && !ctl_q.load_n) |=> count == $past(data_q));
    // R1
    a_r1_step_up: assert property (@(posedge clk) disable iff (rst)
        (ctl_free && edg.up_rise && ctl_q.dn_lvl && !edg.dn_rise)
        |=> count == $past(count) + ONE);
    // R2
    a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
        (ctl_free && edg.dn_rise && ctl_q.up_lvl && !edg.up_rise)
        |=> count == $past(count) - ONE);
    // R3
    a_r3_both_hold: assert property (@(posedge clk) disable iff (rst)
        (ctl_free && edg.up_rise && edg.dn_rise) |=> $stable(count));
    a_r3_blocked_up: assert property (@(posedge clk) disable iff (rst)
        (ctl_free && edg.up_rise && !ctl_q.dn_lvl) |=> $stable(count));
    a_r3_blocked_dn: assert property (@(posedge clk) disable iff (rst)
        (ctl_free && edg.dn_rise && !ctl_q.up_lvl) |=> $stable(count));
    // R10
    a_r10_reset_zero: assert property (@(posedge clk)
        rst |=> count == '0);

endmodule

// File: rtl/dcc_term.sv
module dcc_term #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    logic at_max;
    logic at_zero;

    always_comb begin
        at_max   = (count == CNT_MAX);
        at_zero  = (count == '0);
        carry_n  = ~(at_max & ~up_lvl);
        borrow_n = ~(at_zero & ~dn_lvl);
    end

endmodule

// File: rtl/dual_clock_counter.sv
module dual_clock_counter
    import dcc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_clk,
    input  logic             dn_clk,
    input  logic             load_n,
    input  logic             clear,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    ctl_t             ctl_q;
    edge_t            edg;
    logic [WIDTH-1:0] data_q;

    dcc_sampler #(.WIDTH(WIDTH)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .up_clk (up_clk),
        .dn_clk (dn_clk),
        .load_n (load_n),
        .clear  (clear),
        .data   (data),
        .ctl_q  (ctl_q),
        .edg    (edg),
        .data_q (data_q)
    );

    dcc_count #(.WIDTH(WIDTH)) u_count (
        .clk    (clk),
        .rst    (rst),
        .ctl_q  (ctl_q),
        .edg    (edg),
        .data_q (data_q),
        .count  (count)
    );

    dcc_term #(.WIDTH(WIDTH)) u_term (
        .count    (count),
        .up_lvl   (ctl_q.up_lvl),
        .dn_lvl   (ctl_q.dn_lvl),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    // R4
    a_r4_carry_at_max: assert property (@(posedge clk) disable iff (rst)
        !carry_n |-> count == CNT_MAX);
    a_r4_carry_release: assert property (@(posedge clk) disable iff (rst)
        (edg.up_rise && ctl_q.load_n && !ctl_q.clear) |-> carry_n);
    // R5
    a_r5_borrow_at_zero: assert property (@(posedge clk) disable iff (rst)
        !borrow_n |-> count == '0);
    a_r5_borrow_release: assert property (@(posedge clk) disable iff (rst)
        (edg.dn_rise && ctl_q.load_n && !ctl_q.clear) |-> borrow_n);
    // R10
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (carry_n && borrow_n));

endmodule

// File: tb/dual_clock_counter_bench.sv
module dual_clock_counter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       up_clk = 1'b1;
    logic       dn_clk = 1'b1;
    logic       load_n = 1'b1;
    logic       clear = 1'b0;
    logic [7:0] data = '0;
    logic [3:0] cnt_lo, cnt_hi;
    logic       carry_lo, borrow_lo, carry_hi, borrow_hi;

    int checks = 0;
    int errors = 0;
    int ref_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dual_clock_counter #(.WIDTH(4)) u_dual_clock_counter (
        .clk(clk), .rst(rst), .up_clk(up_clk), .dn_clk(dn_clk),
        .load_n(load_n), .clear(clear), .data(data[3:0]),
        .count(cnt_lo), .carry_n(carry_lo), .borrow_n(borrow_lo));

    dual_clock_counter #(.WIDTH(4)) u_dual_clock_counter_hi (
        .clk(clk), .rst(rst), .up_clk(carry_lo), .dn_clk(borrow_lo),
        .load_n(load_n), .clear(clear), .data(data[7:4]),
        .count(cnt_hi), .carry_n(carry_hi), .borrow_n(borrow_hi));

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_count(string tag);
        check(tag, int'({cnt_hi, cnt_lo}), ref_cnt);
    endtask

    task automatic pulse_up(string tag);
        up_clk = 1'b0;
        settle(3);
        check({tag, " R4 carry low phase"}, int'(carry_lo), ((ref_cnt & 15) == 15) ? 0 : 1);
        up_clk = 1'b1;
        settle(4);
        ref_cnt = (ref_cnt + 1) & 255;
        check_count(tag);
        check({tag, " R4 carry released"}, int'(carry_lo), 1);
    endtask

    task automatic pulse_dn(string tag);
        dn_clk = 1'b0;
        settle(3);
        check({tag, " R5 borrow low phase"}, int'(borrow_lo), ((ref_cnt & 15) == 0) ? 0 : 1);
        dn_clk = 1'b1;
        settle(4);
        ref_cnt = (ref_cnt + 255) & 255;
        check_count(tag);
        check({tag, " R5 borrow released"}, int'(borrow_lo), 1);
    endtask

    task automatic do_load(logic [7:0] v);
        data = v;
        load_n = 1'b0;
        settle(3);
        load_n = 1'b1;
        settle(3);
        ref_cnt = int'(v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst = 1'b0;
        settle(1);
        check("R10 reset count", int'({cnt_hi, cnt_lo}), 0);
        check("R10 reset carry", int'(carry_lo), 1);
        check("R10 reset borrow", int'(borrow_lo), 1);

        // R10 latency: rise applied just after a negedge shows after two posedges
        up_clk = 1'b0;
        settle(3);
        up_clk = 1'b1;
        @(posedge clk); #1;
        check("R10 no change after one edge", int'(cnt_lo), 0);
        @(posedge clk); #1;
        check("R10 change after two edges", int'(cnt_lo), 1);
        ref_cnt = 1;
        settle(3);

        for (int i = 0; i < 4; i++) pulse_up("R1 count up");

        do_load(8'h0E);
        check_count("R6 load 0E");
        pulse_up("R1 to 0F");
        pulse_up("R9 carry into high stage");

        do_load(8'hFF);
        check_count("R6 load FF");
        up_clk = 1'b0;
        settle(3);
        check("R9 high carry low phase", int'(carry_hi), 0);
        up_clk = 1'b1;
        settle(4);
        ref_cnt = 0;
        check_count("R1 R9 wrap FF to 00");

        pulse_dn("R2 R9 wrap 00 to FF");
        for (int i = 0; i < 3; i++) pulse_dn("R2 count down");

        // R3: up edge with down low is ignored; restoring down counts down
        do_load(8'h35);
        dn_clk = 1'b0;
        settle(3);
        up_clk = 1'b0;
        settle(3);
        up_clk = 1'b1;
        settle(4);
        check_count("R3 up blocked by low down");
        dn_clk = 1'b1;
        settle(4);
        ref_cnt = 8'h34;
        check_count("R2 down after restore");

        // R3: simultaneous rises
        up_clk = 1'b0;
        dn_clk = 1'b0;
        settle(3);
        up_clk = 1'b1;
        dn_clk = 1'b1;
        settle(4);
        check_count("R3 simultaneous rises ignored");

        // R6 load with up low, R8 counts after release
        up_clk = 1'b0;
        data = 8'h5A;
        load_n = 1'b0;
        settle(3);
        check("R6 load with strobe low", int'({cnt_hi, cnt_lo}), 8'h5A);
        load_n = 1'b1;
        settle(3);
        up_clk = 1'b1;
        settle(4);
        ref_cnt = 8'h5B;
        check_count("R8 count after load");

        // R7 clear overrides load
        data = 8'hC3;
        load_n = 1'b0;
        clear = 1'b1;
        settle(3);
        check("R7 clear over load", int'({cnt_hi, cnt_lo}), 0);
        load_n = 1'b1;
        dn_clk = 1'b0;
        settle(3);
        clear = 1'b0;
        settle(3);
        check("R5 borrow with count zero", int'(borrow_lo), 0);
        dn_clk = 1'b1;
        settle(5);
        ref_cnt = 8'hFF;
        check_count("R8 down after clear");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule